// File: doc/BRIEF.md
# Integer Conditional Trap Unit

This block sits beside an integer execution pipe and recognises the four conditional trap instructions. Two of them work on 64-bit doublewords and two on 32-bit words, and each size comes in a register-register form and a register-immediate form. When the issue strobe is high, the block decodes the 32-bit instruction word and presents the two source register indices on its outputs. The caller reads its register file combinationally with those indices and drives the two 64-bit operands back in the same cycle, together with the program counter of the instruction.

A five-bit condition mask in the instruction chooses any mix of five tests on the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A trap is taken when at least one chosen test is true. The word forms compare the low halves of the operands after sign-extending them to the full width. The immediate forms compare operand A with a sign-extended 16-bit constant.

One cycle after the issue, the block reports whether the instruction was a trap instruction and whether it trapped. It also latches the faulting program counter and holds it until a clear request arrives.

Top module: `trap_unit`

## Requirements
- R1: The block decodes the following as trap instructions: primary opcode (bits 31:26) 2 is the doubleword-immediate form, and primary opcode 3 is the word-immediate form. Under primary opcode 31, extended opcode (bits 10:1) 4 is the word register form and extended opcode 68 is the doubleword register form. `hit_o` is high one cycle after an issue of any of these four, and low otherwise.
- R2: Any other instruction word never raises `trap_o` or `hit_o`, and it leaves `fault_pc_o` unchanged.
- R3: The mask is bits 25:21. Mask bit 4 traps on signed A<B. Bit 3 traps on signed A>B. Bit 2 traps on A==B. Bit 1 traps on unsigned A<B. Bit 0 traps on unsigned A>B. The trap fires if any enabled test is true.
- R4: A mask of 0 never traps. A mask of 31 always traps.
- R5: The word forms compare bits 31:0 of each operand after sign-extending them to 64 bits. Bits 63:32 have no effect on the result.
- R6: The immediate forms compare operand A with instruction bits 15:0 sign-extended to 64 bits. `opb_i` has no effect on these forms.
- R7: `trap_o` is registered. It is high for exactly the one cycle after an issue that traps, and it never follows a cycle without an issue.
- R8: When a trap fires, `fault_pc_o` takes the `pc_i` of the trapping issue. It then holds until `clr_i` sets it to zero. If a trap and a clear happen in the same cycle, the trap capture wins.
- R9: A synchronous active-low reset clears `trap_o`, `hit_o` and `fault_pc_o`.
- R10: `ra_idx_o` is instruction bits 20:16 and `rb_idx_o` is bits 15:11. Both are combinational from `insn_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction issue strobe |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 64 | Operand A (register selected by ra_idx_o) |
| opb_i | input | 64 | Operand B (register selected by rb_idx_o) |
| pc_i | input | 64 | Program counter of the issued instruction |
| clr_i | input | 1 | Clears the captured fault PC |
| ra_idx_o | output | 5 | Operand A register index |
| rb_idx_o | output | 5 | Operand B register index |
| hit_o | output | 1 | Issued instruction was a trap instruction (registered) |
| trap_o | output | 1 | Trap taken (registered) |
| fault_pc_o | output | 64 | PC of the last trapping instruction |

## Verification
Every one of the 32 mask values is applied with each of the four forms across eight operand pairs. The pairs are chosen so that the tests disagree with one another: signed order against unsigned order, values that differ only in their upper halves, and a pair that crosses the sign boundary of a word. A mismatch in a single mask bit, in the word sign extension or in the immediate extension therefore changes at least one outcome. Word forms carry non-zero upper halves and immediate forms carry a nonzero `opb_i`, which exposes any leak from bits that should have no effect. A sweep over every primary opcode, and over nearby extended opcodes, checks that nothing outside the four encodings is decoded. Directed sequences cover the capture, hold and clear behaviour of the fault PC and the one-cycle width of the trap pulse.

// File: rtl/trap_pkg.sv
// Package: encodings and shared types for the conditional trap unit.
// Assumes a 32-bit instruction word with fixed field positions.
package trap_pkg;

    localparam int INSN_W  = 32;
    localparam int MASK_W  = 5;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int PO_W    = 6;
    localparam int XO_W    = 10;

    // field positions (lsb) inside the instruction word
    localparam int PO_LSB   = 26;
    localparam int MASK_LSB = 21;
    localparam int RA_LSB   = 16;
    localparam int RB_LSB   = 11;
    localparam int XO_LSB   = 1;
    localparam int IMM_LSB  = 0;

    // opcode values
    localparam logic [PO_W-1:0] PO_DW_IMM = 6'd2;
    localparam logic [PO_W-1:0] PO_W_IMM  = 6'd3;
    localparam logic [PO_W-1:0] PO_XGRP   = 6'd31;
    localparam logic [XO_W-1:0] XO_W_REG  = 10'd4;
    localparam logic [XO_W-1:0] XO_DW_REG = 10'd68;

    // position of each test inside the condition mask
    localparam int CB_SLT = 4;
    localparam int CB_SGT = 3;
    localparam int CB_EQ  = 2;
    localparam int CB_ULT = 1;
    localparam int CB_UGT = 0;

    typedef enum logic [2:0] {
        FORM_NONE   = 3'd0,
        FORM_DW_IMM = 3'd1,
        FORM_W_IMM  = 3'd2,
        FORM_W_REG  = 3'd3,
        FORM_DW_REG = 3'd4
    } trap_form_e;

    // true when the form compares word-sized operands
    function automatic logic form_is_word(trap_form_e f);
        return (f == FORM_W_IMM) || (f == FORM_W_REG);
    endfunction

    // true when the second operand comes from the immediate field
    function automatic logic form_is_imm(trap_form_e f);
        return (f == FORM_DW_IMM) || (f == FORM_W_IMM);
    endfunction

endpackage

// File: rtl/trap_decoder.sv
// Module: trap_decoder
// Splits an instruction word into its fields and classifies it as one of
// the four trap forms or as none. Purely combinational; assumes the
// caller qualifies the result with its own issue strobe.
module trap_decoder
    import trap_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output trap_form_e        form_o,
    output logic [MASK_W-1:0] mask_o,
    output logic [RIDX_W-1:0] ra_o,
    output logic [RIDX_W-1:0] rb_o,
    output logic [IMM_W-1:0]  imm_o
);

    logic [PO_W-1:0] po;
    logic [XO_W-1:0] xo;

    // field extraction
    always_comb begin
        po     = insn_i[PO_LSB   +: PO_W];
        xo     = insn_i[XO_LSB   +: XO_W];
        mask_o = insn_i[MASK_LSB +: MASK_W];
        ra_o   = insn_i[RA_LSB   +: RIDX_W];
        rb_o   = insn_i[RB_LSB   +: RIDX_W];
        imm_o  = insn_i[IMM_LSB  +: IMM_W];
    end

    // form classification from primary and extended opcodes
    always_comb begin
        form_o = FORM_NONE;
        unique case (po)
            PO_DW_IMM: form_o = FORM_DW_IMM;
            PO_W_IMM:  form_o = FORM_W_IMM;
            PO_XGRP: begin
                if (xo == XO_W_REG)       form_o = FORM_W_REG;
                else if (xo == XO_DW_REG) form_o = FORM_DW_REG;
                else                      form_o = FORM_NONE;
            end
            default:   form_o = FORM_NONE;
        endcase
    end

endmodule

// File: rtl/trap_operand_sel.sv
// Module: trap_operand_sel
// Produces the two full-width comparison operands for a trap form.
// It narrows and sign-extends the register values for the word forms,
// and sign-extends the immediate for the immediate forms.
// Assumes XLEN is even and wider than the immediate.
module trap_operand_sel
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  trap_form_e        form_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [XLEN-1:0]   cmp_a_o,
    output logic [XLEN-1:0]   cmp_b_o
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] a_word, b_word, imm_ext;

    // sign extension of the low halves and the immediate
    always_comb begin
        a_word  = {{(XLEN-HALF){opa_i[HALF-1]}}, opa_i[HALF-1:0]};
        b_word  = {{(XLEN-HALF){opb_i[HALF-1]}}, opb_i[HALF-1:0]};
        imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end

    // choose the operands by form
    always_comb begin
        cmp_a_o = form_is_word(form_i) ? a_word : opa_i;
        if (form_is_imm(form_i))       cmp_b_o = imm_ext;
        else if (form_is_word(form_i)) cmp_b_o = b_word;
        else                           cmp_b_o = opb_i;
    end

endmodule

// File: rtl/trap_compare.sv
// Module: trap_compare
// Runs the five order tests on two full-width operands and ORs together
// the tests that the mask enables. Combinational.
module trap_compare
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              fire_o
);

    logic [MASK_W-1:0] tests;
    logic [MASK_W-1:0] gated;

    // individual order tests, placed at their mask positions
    always_comb begin
        tests          = '0;
        tests[CB_SLT]  = $signed(a_i) <  $signed(b_i);
        tests[CB_SGT]  = $signed(a_i) >  $signed(b_i);
        tests[CB_EQ]   = a_i == b_i;
        tests[CB_ULT]  = a_i <  b_i;
        tests[CB_UGT]  = a_i >  b_i;
    end

    // per-bit gating by the mask
    for (genvar g = 0; g < MASK_W; g++) begin : g_gate
        assign gated[g] = tests[g] & mask_i[g];
    end

    assign fire_o = |gated;

endmodule

// File: rtl/trap_unit.sv
// Module: trap_unit (top)
// Conditional trap unit. It decodes the issued word, presents the register
// indices to the caller, and registers the hit and trap results one cycle
// after the issue. It also keeps the faulting PC until it is cleared.
// Assumes the operands for the presented indices arrive in the issue cycle.
module trap_unit
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [31:0]       insn_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              clr_i,
    output logic [4:0]        ra_idx_o,
    output logic [4:0]        rb_idx_o,
    output logic              hit_o,
    output logic              trap_o,
    output logic [XLEN-1:0]   fault_pc_o
);

    trap_form_e        form;
    logic [MASK_W-1:0] mask;
    logic [IMM_W-1:0]  imm;
    logic [XLEN-1:0]   cmp_a, cmp_b;
    logic              cond_fire;
    logic              is_trap_insn;
    logic              fire_now;

    logic              hit_q, trap_q;
    logic [XLEN-1:0]   pc_q;

    trap_decoder u_dec (
        .insn_i (insn_i),
        .form_o (form),
        .mask_o (mask),
        .ra_o   (ra_idx_o),
        .rb_o   (rb_idx_o),
        .imm_o  (imm)
    );

    trap_operand_sel #(.XLEN(XLEN)) u_sel (
        .form_i  (form),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .imm_i   (imm),
        .cmp_a_o (cmp_a),
        .cmp_b_o (cmp_b)
    );

    trap_compare #(.XLEN(XLEN)) u_cmp (
        .a_i    (cmp_a),
        .b_i    (cmp_b),
        .mask_i (mask),
        .fire_o (cond_fire)
    );

    // qualify the decode and the condition with the issue strobe
    always_comb begin
        is_trap_insn = (form != FORM_NONE);
        fire_now     = issue_i & is_trap_insn & cond_fire;
    end

    // result registers and fault PC capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            trap_q <= 1'b0;
            pc_q   <= '0;
        end else begin
            hit_q  <= issue_i & is_trap_insn;
            trap_q <= fire_now;
            if (fire_now)   pc_q <= pc_i;
            else if (clr_i) pc_q <= '0;
        end
    end

    assign hit_o      = hit_q;
    assign trap_o     = trap_q;
    assign fault_pc_o = pc_q;

endmodule

// File: rtl/trap_unit_checker.sv
// Module: trap_unit_checker
// Temporal properties on the ports of trap_unit, attached through bind.
module trap_unit_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_i,
    input logic [31:0]     insn_i,
    input logic [XLEN-1:0] pc_i,
    input logic            clr_i,
    input logic            hit_o,
    input logic            trap_o,
    input logic [XLEN-1:0] fault_pc_o
);

    // a trap only follows a cycle with an issue
    assert_trap_needs_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(issue_i));

    // a trap implies a recognised trap instruction
    assert_trap_implies_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> hit_o);

    // an empty mask never traps
    assert_zero_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue_i && insn_i[25:21] == 5'd0) |-> !trap_o);

    // a trap captures the PC of the issue
    assert_pc_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> fault_pc_o == $past(pc_i));

    // without a trap or a clear the captured PC holds
    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !trap_o && !$past(clr_i)) |-> $stable(fault_pc_o));

endmodule

bind trap_unit trap_unit_checker #(.XLEN(XLEN)) u_trap_unit_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .insn_i     (insn_i),
    .pc_i       (pc_i),
    .clr_i      (clr_i),
    .hit_o      (hit_o),
    .trap_o     (trap_o),
    .fault_pc_o (fault_pc_o)
);

// File: tb/trap_unit_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every mask over all forms and a set of operand pairs,
// sweeps non-trap opcodes, and checks PC capture, hold and clear.
module trap_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] opa_i = '0, opb_i = '0, pc_i = '0;
    logic        clr_i = 1'b0;
    logic [4:0]  ra_idx_o, rb_idx_o;
    logic        hit_o, trap_o;
    logic [63:0] fault_pc_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] exp_pc = '0;

    always #4 clk = ~clk;

    trap_unit u_trap_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
        .opa_i(opa_i), .opb_i(opb_i), .pc_i(pc_i), .clr_i(clr_i),
        .ra_idx_o(ra_idx_o), .rb_idx_o(rb_idx_o), .hit_o(hit_o),
        .trap_o(trap_o), .fault_pc_o(fault_pc_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // form 0 dw-imm, 1 w-imm, 2 w-reg, 3 dw-reg
    function automatic logic [31:0] mk(input int form, input logic [4:0] m,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [15:0] imm);
        case (form)
            0:       return {6'd2, m, ra, imm};
            1:       return {6'd3, m, ra, imm};
            2:       return {6'd31, m, ra, rb, 10'd4, 1'b0};
            default: return {6'd31, m, ra, rb, 10'd68, 1'b0};
        endcase
    endfunction

    function automatic logic [63:0] pair_a(input int k);
        case (k)
            0: return 64'd5;
            1: return 64'd3;
            2: return 64'd7;
            3: return 64'hFFFF_FFFF_FFFF_FFFF;
            4: return 64'd1;
            5: return -64'sd5;
            6: return 64'h0000_0001_0000_0000;
            default: return 64'h0000_0000_8000_0000;
        endcase
    endfunction

    function automatic logic [63:0] pair_b(input int k);
        case (k)
            0: return 64'd5;
            1: return 64'd7;
            2: return 64'd3;
            3: return 64'd1;
            4: return 64'hFFFF_FFFF_FFFF_FFFF;
            5: return -64'sd2;
            6: return 64'd0;
            default: return 64'h0000_0000_7FFF_FFFF;
        endcase
    endfunction

    function automatic logic ref_trap(input logic [4:0] m, input logic [63:0] a, input logic [63:0] b);
        return (m[4] && $signed(a) < $signed(b)) || (m[3] && $signed(a) > $signed(b)) ||
               (m[2] && a == b) || (m[1] && a < b) || (m[0] && a > b);
    endfunction

    // one issue; outputs are checked at the following falling edge
    task automatic issue_one(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                             input logic [63:0] pc, input logic exp_hit, input logic exp_trap,
                             input string req);
        @(negedge clk);
        insn_i = w; opa_i = a; opb_i = b; pc_i = pc; issue_i = 1'b1;
        #1;
        check("R10 ra", {59'd0, ra_idx_o}, {59'd0, w[20:16]});
        check("R10 rb", {59'd0, rb_idx_o}, {59'd0, w[15:11]});
        @(negedge clk);
        issue_i = 1'b0;
        if (exp_trap) exp_pc = pc;
        check({req, " hit"},  {63'd0, hit_o},  {63'd0, exp_hit});
        check({req, " trap"}, {63'd0, trap_o}, {63'd0, exp_trap});
        check("R8 fault_pc", fault_pc_o, exp_pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b, ea, eb;
        logic        word;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 hit",   {63'd0, hit_o},  64'd0);
        check("R9 trap",  {63'd0, trap_o}, 64'd0);
        check("R9 fpc",   fault_pc_o,      64'd0);
        rst_n = 1'b1;

        // R1 R3 R4 R5 R6: full mask sweep
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 32; m++) begin
                for (int k = 0; k < 8; k++) begin
                    word = (f == 1) || (f == 2);
                    a = pair_a(k); b = pair_b(k);
                    if (word) begin
                        a = {32'hA5C3_0F96 ^ a[63:32], a[31:0]};
                        ea = {{32{a[31]}}, a[31:0]};
                    end else ea = a;
                    if (f < 2) begin
                        eb = {{48{b[15]}}, b[15:0]};
                        b  = 64'h1234_5678_9ABC_DEF0;
                    end else if (word) begin
                        b  = {32'h5A3C_F069 ^ b[63:32], b[31:0]};
                        eb = {{32{b[31]}}, b[31:0]};
                    end else eb = b;
                    issue_one(mk(f, m[4:0], 5'(k + 3), 5'(m), pair_b(k)), a, b,
                              64'h1000 + 64'(f * 1024 + m * 32 + k), 1'b1,
                              ref_trap(m[4:0], ea, eb),
                              (m == 0 || m == 31) ? "R4" : (word ? "R5" : (f < 2 ? "R6" : "R3")));
                end
            end
        end

        // R7 pulse ends, and no trap without issue
        issue_one(mk(3, 5'd31, 5'd1, 5'd2, 16'd0), 64'd1, 64'd2, 64'hAAAA, 1'b1, 1'b1, "R7");
        @(negedge clk);
        check("R7 pulse width", {63'd0, trap_o}, 64'd0);
        insn_i = mk(3, 5'd31, 5'd1, 5'd2, 16'd0); pc_i = 64'hBBBB;
        @(negedge clk);
        check("R7 no issue", {63'd0, trap_o}, 64'd0);
        check("R7 no issue pc", fault_pc_o, exp_pc);

        // R2: non-trap opcodes with a full mask
        for (int p = 0; p < 64; p++) begin
            if (p != 2 && p != 3 && p != 31)
                issue_one({6'(p), 5'd31, 5'd4, 5'd5, 11'd8}, 64'd1, 64'd9,
                          64'hDEAD_0000 + 64'(p), 1'b0, 1'b0, "R2");
        end
        for (int x = 0; x < 80; x++) begin
            if (x != 4 && x != 68)
                issue_one({6'd31, 5'd31, 5'd4, 5'd5, 10'(x), 1'b0}, 64'd1, 64'd9,
                          64'hBEEF_0000 + 64'(x), 1'b0, 1'b0, "R2 xo");
        end

        // R8 clear, then trap plus clear together
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0; exp_pc = '0;
        check("R8 clear", fault_pc_o, 64'd0);
        @(negedge clk);
        insn_i = mk(0, 5'd4, 5'd2, 5'd0, 16'hFFFF); opa_i = '1; pc_i = 64'h7777;
        issue_i = 1'b1; clr_i = 1'b1;
        @(negedge clk); issue_i = 1'b0; clr_i = 1'b0;
        check("R8 trap beats clear", fault_pc_o, 64'h7777);
        check("R8 trap beats clear trap", {63'd0, trap_o}, 64'd1);

        // R9 reset after capture
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9 fpc after reset", fault_pc_o, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule